// File: doc/BRIEF.md
# Iterative SHA-256 Compression Engine

This block hashes already-padded messages with SHA-256, one 512-bit block at a time. The caller streams sixteen 32-bit words per block under a valid/ready handshake. The engine takes in one word per accepted cycle and runs one compression round per clock in combinational round logic. After round 63 it spends one more cycle adding the working variables into the running hash. With no stalls a block therefore takes 65 clocks.

Storage is kept near the minimum. The block holds the eight working variables, the eight running-hash words and a 16-word sliding window. The window expands the message schedule in place, so the 64 schedule words are never all held at once. A `start` flag presented with the first word of a block begins a new message from the standard initial hash. A block presented without `start` continues from the hash left by the previous block. The `last_blk` flag marks the block whose completion raises the one-cycle `digest_valid` pulse. Padding, and any keyed or derivation construction built on top of the hash, stay with the caller.

Top module: `sha256_iter_core`

## Requirements
- R1: For a single padded block sent with `start` and `last_blk`, `digest` equals the SHA-256 value defined in FIPS 180-4 (for "abc": ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad).
- R2: A block sent without `start` continues from the running hash, so a two-block message gives the standard multi-block result (for the 448-bit test string: 248d6a61 d20638b8 e5c02693 0c3e6039 a33ce459 64ff2167 f6ecedd4 19db06c1).
- R3: Accepting a first word with `start` high reloads the running hash with the eight initial constants 6a09e667 bb67ae85 3c6ef372 a54ff53a 510e527f 9b05688c 1f83d9ab 5be0cd19, whatever message came before.
- R4: `in_ready` is high while idle and during rounds 0 to 15. A word is taken on each clock edge where `in_valid` and `in_ready` are both high, in stream order as schedule words 0 to 15.
- R5: Holding `in_valid` low during rounds 1 to 15 pauses the block without changing the result.
- R6: `in_ready` is low during rounds 16 to 63 and during the add cycle. `in_valid`, `in_word`, `start` and `last_blk` have no effect in those cycles.
- R7: When a block's first word is accepted at clock edge n and no stall follows, the add cycle happens at edge n+64. `digest_valid` is then high for the cycle after that edge.
- R8: `digest_valid` is high for exactly one cycle, only after the add cycle of a block that was flagged with `last_blk` on its first word. It stays low after other blocks.
- R9: `digest` shows the running hash with H0 in bits [255:224] down to H7 in bits [31:0]. It changes only at an add cycle or at the acceptance of a `start` word.
- R10: Synchronous active-high `rst` abandons any block in progress. After reset `in_ready` is high, `digest_valid` is low and `digest` holds the initial constants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | With the first word of a block: begin a new message from the initial hash |
| last_blk | input | 1 | With the first word of a block: this block ends the message |
| in_valid | input | 1 | `in_word` carries a message word |
| in_word | input | 32 | Message word, big-endian order within the block |
| in_ready | output | 1 | The engine takes a word on this edge if `in_valid` is high |
| digest_valid | output | 1 | One-cycle pulse when a final block completes |
| digest | output | 256 | Running hash, H0 in the most significant word |

## Verification
A wrong round, constant or schedule tap corrupts a working variable. That error stays inside the block until the add cycle, 65 clocks after the first word at the earliest, and then shows up as a wrong `digest` compared against the standard hash values. A fault in the round counter or phase logic shows up sooner, as `in_ready` or `digest_valid` toggling in the wrong cycle. The bench's per-cycle model flags such a fault on the first cycle it differs. A window that shifts during a stall, or a running hash that loads at the wrong time, shows up as a wrong final digest or as `digest` moving while it should stay still.

// File: rtl/sha256_core_pkg.sv
package sha256_core_pkg;

    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int ROUNDS    = 64;
    localparam int RND_W     = $clog2(ROUNDS);
    localparam int DIG_W     = 8 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } wvars_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_ADD
    } phase_t;

    localparam wvars_t HASH_INIT = '{
        a: 32'h6a09e667, b: 32'hbb67ae85, c: 32'h3c6ef372, d: 32'ha54ff53a,
        e: 32'h510e527f, f: 32'h9b05688c, g: 32'h1f83d9ab, h: 32'h5be0cd19
    };

    localparam word_t RCONST [ROUNDS] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic word_t rotr(word_t x, int unsigned n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t small_sig0(word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t small_sig1(word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t choose(word_t x, word_t y, word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t majority(word_t x, word_t y, word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic wvars_t lane_add(wvars_t p, wvars_t q);
        wvars_t s;
        s.a = p.a + q.a;
        s.b = p.b + q.b;
        s.c = p.c + q.c;
        s.d = p.d + q.d;
        s.e = p.e + q.e;
        s.f = p.f + q.f;
        s.g = p.g + q.g;
        s.h = p.h + q.h;
        return s;
    endfunction

endpackage

// File: rtl/sha256_round.sv
module sha256_round
    import sha256_core_pkg::*;
(
    input  wvars_t cur,
    input  word_t  kt,
    input  word_t  wt,
    output wvars_t nxt
);
    word_t t1;
    word_t t2;

    always_comb begin
        t1 = cur.h + big_sig1(cur.e) + choose(cur.e, cur.f, cur.g) + kt + wt;
        t2 = big_sig0(cur.a) + majority(cur.a, cur.b, cur.c);
        nxt.h = cur.g;
        nxt.g = cur.f;
        nxt.f = cur.e;
        nxt.e = cur.d + t1;
        nxt.d = cur.c;
        nxt.c = cur.b;
        nxt.b = cur.a;
        nxt.a = t1 + t2;
    end
endmodule

// File: rtl/sha256_msg_window.sv
module sha256_msg_window
    import sha256_core_pkg::*;
#(
    parameter int DEPTH = BLK_WORDS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  use_input,
    input  word_t in_word,
    output word_t wt
);
    logic [DEPTH-1:0][WORD_W-1:0] win;
    word_t expanded;

    // win[DEPTH-1] is W(t-1), win[0] is W(t-16)
    always_comb begin
        expanded = small_sig1(win[DEPTH-2]) + win[DEPTH-7]
                 + small_sig0(win[1]) + win[0];
        wt = use_input ? in_word : expanded;
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH - 1; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    win[gi] <= '0;
                else if (shift_en)
                    win[gi] <= win[gi+1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            win[DEPTH-1] <= '0;
        else if (shift_en)
            win[DEPTH-1] <= wt;
    end

    // R5: a stalled cycle must leave the schedule window untouched
    a_r5_window_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(win));
endmodule

// File: rtl/sha256_iter_core.sv
module sha256_iter_core
    import sha256_core_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         last_blk,
    input  logic         in_valid,
    input  logic [31:0]  in_word,
    output logic         in_ready,
    output logic         digest_valid,
    output logic [255:0] digest
);
    phase_t           phase;
    logic [RND_W-1:0] rnd;
    logic             blk_last;
    wvars_t           wv;
    wvars_t           hv;
    wvars_t           rnd_in;
    wvars_t           rnd_out;
    word_t            wt;
    logic             in_phase;
    logic             take_first;
    logic             step;

    assign in_phase   = (rnd < RND_W'(BLK_WORDS));
    assign take_first = (phase == PH_IDLE) && in_valid;
    assign step       = take_first || ((phase == PH_RUN) && (!in_phase || in_valid));
    assign in_ready   = (phase == PH_IDLE) || ((phase == PH_RUN) && in_phase);
    assign rnd_in     = take_first ? (start ? HASH_INIT : hv) : wv;
    assign digest     = hv;

    sha256_msg_window #(.DEPTH(BLK_WORDS)) u_window (
        .clk      (clk),
        .rst      (rst),
        .shift_en (step),
        .use_input(in_phase),
        .in_word  (in_word),
        .wt       (wt)
    );

    sha256_round u_round (
        .cur(rnd_in),
        .kt (RCONST[rnd]),
        .wt (wt),
        .nxt(rnd_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            rnd          <= '0;
            blk_last     <= 1'b0;
            digest_valid <= 1'b0;
        end else begin
            digest_valid <= 1'b0;
            unique case (phase)
                PH_IDLE: if (in_valid) begin
                    rnd      <= RND_W'(1);
                    blk_last <= last_blk;
                    phase    <= PH_RUN;
                end
                PH_RUN: if (step) begin
                    rnd <= rnd + RND_W'(1);
                    if (rnd == RND_W'(ROUNDS - 1))
                        phase <= PH_ADD;
                end
                PH_ADD: begin
                    digest_valid <= blk_last;
                    phase        <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hv <= HASH_INIT;
        else if (take_first && start)
            hv <= HASH_INIT;
        else if (phase == PH_ADD)
            hv <= lane_add(hv, wv);
    end

    always_ff @(posedge clk) begin
        if (step)
            wv <= rnd_out;
    end

    a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
        digest_valid |=> !digest_valid);

    a_r8_pulse_after_add: assert property (@(posedge clk) disable iff (rst)
        $rose(digest_valid) |-> $past(phase == PH_ADD));

    a_r9_digest_hold: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_ADD && !(take_first && start)) |=> $stable(digest));

    a_r7_round_advance: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && !in_ready) |=> (rnd == $past(rnd) + RND_W'(1)));

    a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !digest_valid));
endmodule

// File: tb/tb_sha256_iter_core.sv
module tb_sha256_iter_core;
    import sha256_core_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         last_blk = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_word = '0;
    logic         in_ready;
    logic         digest_valid;
    logic [255:0] digest;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit chk_en = 0;

    localparam logic [255:0] IV_DIG   = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
    localparam logic [255:0] ABC_DIG  = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    localparam logic [255:0] TWO_DIG  = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;

    sha256_iter_core dut (
        .clk(clk), .rst(rst), .start(start), .last_blk(last_blk),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .digest_valid(digest_valid), .digest(digest)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural reference ----------------
    function automatic word_t rr(word_t x, int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [255:0] ref_block(logic [255:0] hin, word_t m[16]);
        word_t w[64];
        word_t v[8];
        word_t t1, t2;
        logic [255:0] hout;
        for (int t = 0; t < 64; t++) begin
            if (t < 16) w[t] = m[t];
            else w[t] = (rr(w[t-2],17) ^ rr(w[t-2],19) ^ (w[t-2] >> 10)) + w[t-7]
                      + (rr(w[t-15],7) ^ rr(w[t-15],18) ^ (w[t-15] >> 3)) + w[t-16];
        end
        for (int i = 0; i < 8; i++) v[i] = hin[255-32*i -: 32];
        for (int t = 0; t < 64; t++) begin
            t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + RCONST[t] + w[t];
            t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            for (int j = 7; j > 0; j--) v[j] = v[j-1];
            v[4] = v[4] + t1;
            v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) hout[255-32*i -: 32] = hin[255-32*i -: 32] + v[i];
        return hout;
    endfunction

    word_t        mq[$];
    logic [255:0] m_h = IV_DIG;
    bit           m_busy = 0;
    int           m_cnt = 0;
    bit           m_last = 0;
    bit           m_dv = 0;

    always @(posedge clk) begin
        word_t blk[16];
        chk_en = 1;
        m_dv = 0;
        if (rst) begin
            m_busy = 0; m_cnt = 0; mq.delete(); m_h = IV_DIG;
        end else if (!m_busy) begin
            if (in_valid) begin
                m_busy = 1; m_cnt = 1; m_last = last_blk;
                if (start) m_h = IV_DIG;
                mq.push_back(in_word);
            end
        end else if (m_cnt < 16) begin
            if (in_valid) begin mq.push_back(in_word); m_cnt++; end
        end else if (m_cnt < 64) begin
            m_cnt++;
        end else begin
            for (int i = 0; i < 16; i++) blk[i] = mq[i];
            mq.delete();
            m_h = ref_block(m_h, blk);
            m_busy = 0; m_cnt = 0; m_dv = m_last;
        end
    end

    task automatic check1(string req, string what, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R4 R6 R8 R9)
    always @(negedge clk) begin
        if (chk_en) begin
            check1("R4/R6", "in_ready", {255'd0, in_ready}, {255'd0, (!m_busy || m_cnt < 16)});
            check1("R8", "digest_valid", {255'd0, digest_valid}, {255'd0, m_dv});
            check1("R9", "digest", digest, m_h);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_block(input word_t blk[16], input bit st, input bit lst,
                              input bit stall, input bit junk, output int t0);
        int i = 0;
        bit skipped = 0;
        bit fin = 0;
        t0 = 0;
        while (i < 16) begin
            @(negedge clk);
            if (stall && !skipped && (i % 5 == 2)) begin
                in_valid = 0; skipped = 1;
            end else begin
                skipped = 0;
                in_valid = 1; in_word = blk[i];
                start = st && (i == 0); last_blk = lst;
                if (in_ready) begin
                    if (i == 0) t0 = cyc + 1;
                    i++;
                end
            end
        end
        while (!fin) begin
            @(negedge clk);
            if (in_ready) begin
                in_valid = 0; start = 0; last_blk = 0; fin = 1;
            end else begin
                in_valid = junk; in_word = 32'hdeadbeef ^ cyc; start = junk; last_blk = junk;
            end
        end
    endtask

    word_t abc_blk[16];
    word_t two_a[16];
    word_t two_b[16];
    int    t0;

    initial begin
        for (int i = 0; i < 16; i++) begin abc_blk[i] = '0; two_b[i] = '0; end
        abc_blk[0] = 32'h61626380; abc_blk[15] = 32'h00000018;
        for (int i = 0; i < 14; i++)
            two_a[i] = {8'h61 + 8'(i), 8'h62 + 8'(i), 8'h63 + 8'(i), 8'h64 + 8'(i)};
        two_a[14] = 32'h80000000; two_a[15] = 32'h0;
        two_b[15] = 32'h000001c0;

        repeat (3) @(negedge clk);
        // R10: reset state
        check1("R10", "ready after reset", {255'd0, in_ready}, {255'd0, 1'b1});
        check1("R10", "dv after reset", {255'd0, digest_valid}, 256'd0);
        check1("R10", "digest after reset", digest, IV_DIG);
        rst = 0;

        // R1 R7: single block, no stall
        send_block(abc_blk, 1, 1, 0, 0, t0);
        check1("R1", "abc digest", digest, ABC_DIG);
        check1("R7", "latency", 256'(cyc - t0), 256'd64);
        check1("R8", "pulse on last", {255'd0, digest_valid}, {255'd0, 1'b1});

        // R2 R8 R9: two-block message
        send_block(two_a, 1, 0, 0, 0, t0);
        check1("R8", "no pulse mid-message", {255'd0, digest_valid}, 256'd0);
        send_block(two_b, 0, 1, 0, 0, t0);
        check1("R2", "two-block digest", digest, TWO_DIG);
        check1("R9", "H0 in top word", {224'd0, digest[255:224]}, {224'd0, 32'h248d6a61});

        // R3 R5 R6: restart after a message, with stalls and junk in rounds 16+
        send_block(abc_blk, 1, 1, 1, 1, t0);
        check1("R3", "restart digest", digest, ABC_DIG);
        check1("R5", "stall result", {255'd0, digest_valid}, {255'd0, 1'b1});

        // R9: digest holds while idle
        repeat (10) @(negedge clk);
        check1("R9", "digest hold", digest, ABC_DIG);
        check1("R8", "pulse gone", {255'd0, digest_valid}, 256'd0);

        // R10: reset mid-block
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1; in_word = two_a[i]; start = (i == 0); last_blk = 1;
        end
        @(negedge clk);
        in_valid = 0; start = 0; last_blk = 0; rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check1("R10", "ready after mid reset", {255'd0, in_ready}, {255'd0, 1'b1});
        check1("R10", "digest after mid reset", digest, IV_DIG);
        send_block(abc_blk, 1, 1, 0, 0, t0);
        check1("R1", "abc after reset", digest, ABC_DIG);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule